// File: doc/BRIEF.md
# SPI Register Slave with Pipelined Read Replies

This block lets an external SPI master reach a bank of 16-bit registers. The four serial pins are brought into the fast system clock domain through synchronisers, and edges of the serial clock are found there. Every complete 16-bit frame is decoded as either a byte write or a read request. A write changes one byte of one register. A read request gives nothing back in its own frame. The addressed register is shifted out on the data output during the frame that follows, so a master working full duplex can send the next read command while it receives the previous result. When chip select is high, the data output is released. This is modelled with an output-enable pin.

The bank is also the output side of a sampling datapath. A load port writes whole 16-bit registers, and each load raises a one-cycle data-ready pulse for an interrupt pin. A second read port lets the surrounding logic read configuration values. A fixed identification word answers at its own address.

Top module: `spi_regbank_slave`

## Requirements
- R1: The serial link uses clock polarity 1 and phase 1. Input bits are taken on rising serial-clock edges, and the output changes on falling edges. Frames are 16 bits, MSB first, and are bounded by a low chip select. In a frame, bit 15 = 1 means write and 0 means read. Bits 14:8 are the 7-bit byte address and bits 7:0 are the write byte.
- R2: A write frame updates exactly one byte. An even address selects bits 7:0 of register address/2, and an odd address selects bits 15:8. The other byte keeps its value (for example, frame 0xB807 puts 0x07 in the low byte of register 28). The register is visible on the local read port.
- R3: A read frame returns register address/2 MSB first during the next complete frame. Byte addresses 0x40–0x7F other than the identification pair read as 0x0000.
- R4: The frame after a write frame, and the first frame after reset, shifts out 0x0000.
- R5: A frame in which chip select rises before 16 bits have arrived is discarded. It performs no write and leaves the pending read unchanged.
- R6: The output enable is low while chip select is high and high while it is low, with a lag of a few system clocks.
- R7: Byte addresses 0x56 and 0x57 read back the ID_VALUE parameter. Writes to them, or to any address of 0x40 or above, change nothing.
- R8: A sample load stores a whole 16-bit register and makes data-ready high for exactly the one cycle after the load. A load takes precedence over a serial write to the same register in the same cycle.
- R9: Back-to-back read frames each return the result of the read frame before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the master, idle high |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from the master |
| dout | output | 1 | Serial data to the master |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |
| smp_load | input | 1 | Sample-update strobe |
| smp_idx | input | 5 | Register index loaded by the strobe |
| smp_data | input | 16 | Register value loaded by the strobe |
| rd_idx | input | 5 | Local read port register index |
| rd_data | output | 16 | Local read port data |
| drdy | output | 1 | Data-ready pulse |

## Verification
The bench tracks the pending read on its own. That way a slave that answers in the same frame, or that forgets a read across a write, returns the wrong word. Odd and even writes are mixed and later read back in full, so a byte-lane swap or a whole-word write shows up as corrupted neighbouring bytes. Aborted frames are placed between a read and its reply. A slave that counts a short frame would then write a byte or replace the pending address. Writes to the identification and unmapped ranges are followed by reads of those addresses, which catches a decoder that aliases high addresses onto the bank.

// File: rtl/spi_rb_pkg.sv
// Package: shared constants and the decoded frame layout for the SPI
// register slave. Assumes 16-bit frames with a 7-bit byte address.
package spi_rb_pkg;
    localparam int FRAME_W = 16;
    localparam int ADDR_W  = 7;
    localparam int BYTE_W  = 8;

    typedef struct packed {
        logic              wr;    // 1 = byte write, 0 = read request
        logic [ADDR_W-1:0] addr;  // byte address
        logic [BYTE_W-1:0] data;  // write byte
    } frame_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: brings sclk, cs_n and din into the clk domain and flags edges.
// Assumes the serial clock half period spans several system clocks
// (STAGES+1 at least), so a single sample of each level is seen.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_low,
    output logic din_s
);
    logic [STAGES-1:0] sclk_q, cs_q, din_q;
    logic              sclk_prev, cs_prev;

    // Synchroniser chains; idle levels are high clock and deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= '1;
            cs_q      <= '1;
            din_q     <= '0;
            sclk_prev <= 1'b1;
            cs_prev   <= 1'b1;
        end else begin
            sclk_q    <= {sclk_q[STAGES-2:0], sclk};
            cs_q      <= {cs_q[STAGES-2:0], cs_n};
            din_q     <= {din_q[STAGES-2:0], din};
            sclk_prev <= sclk_q[STAGES-1];
            cs_prev   <= cs_q[STAGES-1];
        end
    end

    // Edge and level flags from the last synchroniser stage.
    always_comb begin
        sclk_rise = sclk_q[STAGES-1] & ~sclk_prev;
        sclk_fall = ~sclk_q[STAGES-1] & sclk_prev;
        cs_fall   = ~cs_q[STAGES-1] & cs_prev;
        cs_low    = ~cs_q[STAGES-1];
        din_s     = din_q[STAGES-1];
    end
endmodule

// File: rtl/spi_frame_rx.sv
// Module: assembles MSB-first frames from rising serial-clock edges.
// Emits one valid pulse after exactly FRAME_W bits; bits beyond that
// are ignored, and a frame cut short by chip select leaves no trace.
module spi_frame_rx
    import spi_rb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               cs_fall,
    input  logic               cs_low,
    input  logic               din_s,
    output logic               frame_vld,
    output logic [FRAME_W-1:0] frame_word
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bitcnt;

    // Shift in bits and raise valid on the last bit of a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bitcnt     <= '0;
            frame_vld  <= 1'b0;
            frame_word <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (cs_fall) begin
                bitcnt <= '0;
            end else if (cs_low && sclk_rise && bitcnt != FULL) begin
                shreg  <= {shreg[FRAME_W-2:0], din_s};
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == LAST) begin
                    frame_vld  <= 1'b1;
                    frame_word <= {shreg[FRAME_W-2:0], din_s};
                end
            end
        end
    end
endmodule

// File: rtl/spi_reg_bank.sv
// Module: bank of NREGS 16-bit registers. Serial writes are one byte
// wide, sample loads are whole words and win over a same-cycle serial
// write to the same register. Assumes the ID word lies above the bank.
module spi_reg_bank
    import spi_rb_pkg::*;
#(
    parameter int                NREGS    = 32,
    parameter logic [ADDR_W-1:0] ID_ADDR  = 7'h56,
    parameter logic [15:0]       ID_VALUE = 16'hA51C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_we,
    input  logic [ADDR_W-1:0] spi_addr,
    input  logic [BYTE_W-1:0] spi_byte,
    input  logic              smp_we,
    input  logic [$clog2(NREGS)-1:0] smp_idx,
    input  logic [15:0]       smp_data,
    input  logic [ADDR_W-2:0] rda_word,
    output logic [15:0]       rda_data,
    input  logic [$clog2(NREGS)-1:0] rdb_idx,
    output logic [15:0]       rdb_data
);
    localparam int WORD_W = ADDR_W - 1;
    localparam int IDX_W  = $clog2(NREGS);
    localparam logic [WORD_W-1:0] ID_WORD = ID_ADDR[ADDR_W-1:1];

    logic [15:0]       regs [NREGS];
    logic [WORD_W-1:0] wr_word;
    logic              wr_ok;

    // Decode which word a serial write targets and whether it may land.
    always_comb begin
        wr_word = spi_addr[ADDR_W-1:1];
        wr_ok   = spi_we && (wr_word < WORD_W'(NREGS)) && (wr_word != ID_WORD);
    end

    genvar g;
    generate
        for (g = 0; g < NREGS; g++) begin : g_reg
            // One register: whole-word load first, then byte-lane write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (smp_we && smp_idx == IDX_W'(g)) begin
                    regs[g] <= smp_data;
                end else if (wr_ok && wr_word == WORD_W'(g)) begin
                    if (spi_addr[0]) regs[g][15:8] <= spi_byte;
                    else             regs[g][7:0]  <= spi_byte;
                end
            end
        end
    endgenerate

    // Serial read port: ID word, bank word, or zero when unmapped.
    always_comb begin
        if (rda_word == ID_WORD)              rda_data = ID_VALUE;
        else if (rda_word < WORD_W'(NREGS))   rda_data = regs[rda_word[IDX_W-1:0]];
        else                                  rda_data = '0;
    end

    // Local read port for the surrounding logic.
    always_comb rdb_data = regs[rdb_idx];
endmodule

// File: rtl/spi_regbank_slave.sv
// Module: top of the SPI register slave. Decodes frames, keeps the
// pending read address, shifts the reply out in the following frame
// and pulses data-ready on sample loads. Assumes mode 3 masters.
module spi_regbank_slave
    import spi_rb_pkg::*;
#(
    parameter int          NREGS       = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] ID_VALUE    = 16'hA51C
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        din,
    output logic        dout,
    output logic        dout_oe,
    input  logic        smp_load,
    input  logic [4:0]  smp_idx,
    input  logic [15:0] smp_data,
    input  logic [4:0]  rd_idx,
    output logic [15:0] rd_data,
    output logic        drdy
);
    localparam int WORD_W = ADDR_W - 1;

    logic               sclk_rise, sclk_fall, cs_fall, cs_low, din_s;
    logic               frame_vld;
    logic [FRAME_W-1:0] frame_word;
    frame_t             frm;
    logic               spi_we;
    logic [ADDR_W-1:0]  spi_addr;
    logic               pend_vld;
    logic [WORD_W-1:0]  pend_word;
    logic [15:0]        reply;
    logic [FRAME_W-1:0] tx_sr;
    logic               tx_first;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_low(cs_low), .din_s(din_s)
    );

    spi_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .cs_fall(cs_fall),
        .cs_low(cs_low), .din_s(din_s),
        .frame_vld(frame_vld), .frame_word(frame_word)
    );

    // Split the received word into its fields.
    always_comb begin
        frm      = frame_t'(frame_word);
        spi_we   = frame_vld && frm.wr;
        spi_addr = frm.addr;
    end

    spi_reg_bank #(.NREGS(NREGS), .ID_VALUE(ID_VALUE)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .spi_we(spi_we), .spi_addr(spi_addr), .spi_byte(frm.data),
        .smp_we(smp_load), .smp_idx(smp_idx), .smp_data(smp_data),
        .rda_word(pend_word), .rda_data(reply),
        .rdb_idx(rd_idx), .rdb_data(rd_data)
    );

    // Remember the last complete read request; writes clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_word <= '0;
        end else if (frame_vld) begin
            pend_vld  <= !frm.wr;
            if (!frm.wr) pend_word <= frm.addr[ADDR_W-1:1];
        end
    end

    // Reply shifter: load at select, hold the MSB over the first falling
    // edge, then advance one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr    <= '0;
            tx_first <= 1'b0;
        end else if (cs_fall) begin
            tx_sr    <= pend_vld ? reply : '0;
            tx_first <= 1'b1;
        end else if (cs_low && sclk_fall) begin
            if (tx_first) tx_first <= 1'b0;
            else          tx_sr    <= {tx_sr[FRAME_W-2:0], 1'b0};
        end
    end

    // Data-ready follows each sample load by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) drdy <= 1'b0;
        else        drdy <= smp_load;
    end

    // Output pin and its enable.
    always_comb begin
        dout_oe = cs_low;
        dout    = cs_low & tx_sr[FRAME_W-1];
    end
endmodule

// File: rtl/spi_regbank_slave_chk.sv
// Checker: temporal properties of the SPI register slave, bound below.
module spi_regbank_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic dout_oe,
    input logic smp_load,
    input logic drdy,
    input logic frame_vld,
    input logic spi_we,
    input logic cs_low,
    input logic pend_vld
);
    // Output enable only rises after the pin went low (R6).
    p_oe_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(!cs_n));
    // Output enable only falls after the pin went high (R6).
    p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_oe) |-> $past(cs_n));
    // A frame completes only while selected, and never twice in a row (R1, R5).
    p_frame_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> cs_low);
    p_frame_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |=> !frame_vld);
    // After a write frame no read is pending (R4).
    p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_we |=> !pend_vld);
    // Data-ready is exactly the delayed load strobe (R8).
    p_drdy_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_load |=> drdy);
    p_drdy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drdy |-> $past(smp_load));
endmodule

bind spi_regbank_slave spi_regbank_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout_oe(dout_oe),
    .smp_load(smp_load), .drdy(drdy), .frame_vld(frame_vld),
    .spi_we(spi_we), .cs_low(cs_low), .pend_vld(pend_vld)
);

// File: tb/spi_regbank_slave_test.sv
// Bench: seeded random frames mixed with directed corner cases, checked
// against a bench-side model of the register bank and pending read.
module spi_regbank_slave_test;
    localparam logic [15:0] IDV = 16'hA51C;
    localparam time H = 60ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
    logic dout, dout_oe, drdy;
    logic smp_load = 1'b0;
    logic [4:0] smp_idx = '0, rd_idx = '0;
    logic [15:0] smp_data = '0, rd_data;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [15:0] model [32];
    bit          exp_pend = 0;
    logic [6:0]  exp_addr = '0;

    always #2.5ns clk = ~clk;

    spi_regbank_slave uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .smp_load(smp_load),
        .smp_idx(smp_idx), .smp_data(smp_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .drdy(drdy)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input logic [6:0] a);
        if (a[6:1] == 6'h2B)  return IDV;
        if (a[6:1] < 6'd32)   return model[a[5:1]];
        return 16'h0000;
    endfunction

    // One frame of nbits; full frames are checked against the model.
    task automatic xfer(input logic [15:0] mosi, input int nbits, input string req);
        logic [15:0] miso = '0;
        logic [15:0] exp;
        exp = exp_pend ? word_of(exp_addr) : 16'h0000;
        cs_n = 1'b0; #H;
        check("R6 oe while selected", {15'd0, dout_oe}, 16'd1);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0; din = mosi[15-i]; #H;
            miso[15-i] = dout;
            sclk = 1'b1; #H;
        end
        #H; cs_n = 1'b1; #H;
        if (nbits == 16) begin
            check(req, miso, exp);
            if (mosi[15]) begin
                if (mosi[14:9] < 6'd32) begin
                    if (mosi[8]) model[mosi[13:9]][15:8] = mosi[7:0];
                    else         model[mosi[13:9]][7:0]  = mosi[7:0];
                end
                exp_pend = 0;
            end else begin
                exp_pend = 1;
                exp_addr = mosi[14:8];
            end
        end
        check("R6 oe released", {15'd0, dout_oe}, 16'd0);
    endtask

    task automatic load(input logic [4:0] idx, input logic [15:0] v);
        @(negedge clk);
        smp_load = 1'b1; smp_idx = idx; smp_data = v;
        @(negedge clk);
        smp_load = 1'b0;
        check("R8 drdy pulse", {15'd0, drdy}, 16'd1);
        model[idx] = v;
        @(negedge clk);
        check("R8 drdy single", {15'd0, drdy}, 16'd0);
        rd_idx = idx;
        #1ns;
        check("R8 load visible", rd_data, v);
    endtask

    function automatic logic [6:0] pick_addr();
        int r = $urandom % 8;
        if (r == 0) return 7'h56 | 7'($urandom % 2);
        if (r == 1) return 7'h40 + 7'($urandom % 64);
        return 7'($urandom % 64);
    endfunction

    initial begin
        #(200000 * 5ns);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 reset oe", {15'd0, dout_oe}, 16'd0);
        check("R8 reset drdy", {15'd0, drdy}, 16'd0);

        // R4: first frame after reset replies zero.
        xfer(16'h0400, 16, "R4 zero after reset");
        // R2: the write example lands in the low byte of word 28.
        xfer(16'hB807, 16, "R2 write frame");
        rd_idx = 5'd28; #1ns;
        check("R2 low byte lane", rd_data, 16'h0007);
        xfer(16'hB9C3, 16, "R4 zero after write");
        rd_idx = 5'd28; #1ns;
        check("R2 high byte lane", rd_data, 16'hC307);
        // R9: pipelined reads.
        xfer(16'h3800, 16, "R4 zero after write");
        xfer(16'h5600, 16, "R9 reply of word 28");
        xfer(16'h5700, 16, "R7 ID low address");
        xfer(16'h4000, 16, "R7 ID odd address");
        // R7: writes to ID and unmapped ranges are ignored.
        xfer(16'hD6FF, 16, "R9 unmapped read");
        xfer(16'hC1FF, 16, "R4 zero after write");
        xfer(16'h5600, 16, "R4 zero after write");
        xfer(16'h4100, 16, "R7 ID after write attempt");
        xfer(16'h0000, 16, "R7 unmapped stays zero");
        // R5: aborted frames between a read and its reply.
        load(5'd3, 16'hBEEF);
        xfer(16'h0600, 16, "R3 read word 0");
        xfer(16'h86AA, 9, "R5 aborted write");
        xfer(16'h1000, 7, "R5 aborted read");
        xfer(16'h0600, 16, "R5 pending kept");
        xfer(16'h0000, 16, "R5 no write from abort");

        // Random mix.
        for (int n = 0; n < 160; n++) begin
            int op = $urandom % 8;
            logic [6:0] a = pick_addr();
            if (op <= 2)      xfer({1'b0, a, 8'($urandom)}, 16, "R3 R9 random read");
            else if (op <= 4) xfer({1'b1, a, 8'($urandom)}, 16, "R1 R2 random write");
            else if (op == 5) xfer({1'($urandom), a, 8'($urandom)}, 1 + int'($urandom % 15), "R5 random abort");
            else if (op == 6) load(5'($urandom), 16'($urandom));
            else begin
                rd_idx = 5'($urandom); #1ns;
                check("R2 local read port", rd_data, model[rd_idx]);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule